// File: doc/BRIEF.md
# Programmable Raster Sync Generator

The block derives horizontal, vertical and composite sync and blanking strobes for a raster display from a single pixel clock. A pixel counter and a line counter run against a bank of sixteen 12-bit timing registers. Every pulse edge is a compare between a counter and one of these registers, so line rate and field rate follow only from the register contents and the clock.

Register 0 is the mode word. It selects progressive or interlaced scan, separate or composite outputs, serration and equalization insertion into composite sync, and a run bit that freezes both counters so the timing can be rewritten before start-up. When the composite outputs are selected, the two freed pins carry a horizontal gate and a vertical gate, and two more pins carry a cursor strobe and a vertical interrupt strobe. A synchronous clear reloads broadcast-television timing (910 clocks by 525 lines, interlaced) and parks the counters at zero. A build parameter sets the run bit that this reload writes, so the block either waits to be programmed or starts straight after the clear.

Top module: `raster_sync_gen`

## Requirements
- R1: An asynchronous reset (rst_ni low), or clear_i sampled high at a clock edge, loads the default registers and zeroes both counters. On the next edge all six outputs are forced high. Defaults by address: 0 = 0x00F with bit 10 equal to CLK_EN_DEFAULT; 1 = 910; 2 = 0; 3 = 67; 4 = 890; 5 = 150; 6 = 525; 7 = 3; 8 = 6; 9 = 0; 10 = 20; 11 = 33; 12 = 67; 13 = 455; 14 = 100; 15 = 262.
- R2: Bit 10 of register 0 is the run bit. While it is 0, both counters hold their values, so with no register write the outputs stay constant.
- R3: The pixel counter h counts 0 to htot-1 (htot = register 1) and then returns to 0. On that return the line counter v advances, and it wraps to 0 after vtot-1 (vtot = register 6). A total written below the current count wraps at the next step.
- R4: A window [s,e) covers x with s <= x < e when s <= e, and covers x with x >= s or x < e when s > e. Horizontal sync is the window of h over registers 2 and 3. Horizontal blank is the window of h over registers 4 and 5.
- R5: The vertical position is counted in half-lines: p = 2v + (h >= htot/2). In progressive mode (status bit 1 = 0), f = p. Vertical sync is the window of f over twice registers 7 and 8. Vertical blank is the window of f over twice registers 9 and 10.
- R6: In interlaced mode (status bit 1 = 1), f = p - vtot whenever p >= vtot. With an odd vtot, the second field's vertical events therefore start half a line later.
- R7: Composite sync (status bit 0 = 1) follows horizontal sync outside the vertical sync window. Inside that window, with serration off, it is active for the whole window.
- R8: With serration on (status bit 2), composite sync inside the vertical sync window is active only while hh + register 12 < htot/2. Here hh is h, less htot/2 in the second half of the line.
- R9: With equalization on (status bit 3), in the EQ_LINES lines before and after the vertical sync window (f in [2*reg7 - 2*EQ_LINES, 2*reg7) or [2*reg8, 2*reg8 + 2*EQ_LINES)), composite sync is active while hh < register 11.
- R10: In composite mode, the second pin carries composite blank: horizontal blank OR vertical blank.
- R11: In composite mode, the third pin is the horizontal gate (window of h over registers 3 and 5). The fourth pin is the vertical gate (window of f over twice registers 8 and 10). cursor_o is active when h = reg13 and v = reg14. vint_o is active while v = reg15. In separate mode, cursor_o and vint_o stay high.
- R12: All outputs are active-low and registered. Each output reflects the counters and registers as they were before the edge that updates it. A write at address wr_addr_i is visible from the following compare, even while the counters run.
- R13: After a clear followed by setting the run bit, the block produces the default 910 x 525 interlaced composite timing with serration and equalization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous reload of default registers |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 12 | Register write data |
| hsync_csync_o | output | 1 | Horizontal sync, or composite sync in composite mode (active low) |
| vsync_cblank_o | output | 1 | Vertical sync, or composite blank (active low) |
| hblank_hgate_o | output | 1 | Horizontal blank, or horizontal gate (active low) |
| vblank_vgate_o | output | 1 | Vertical blank, or vertical gate (active low) |
| cursor_o | output | 1 | Cursor position strobe in composite mode (active low) |
| vint_o | output | 1 | Vertical interrupt strobe in composite mode (active low) |

## Verification
The bench targets windows that wrap past the line end. A design that treats every window as ordered would lose the blanking across h = 0. It also targets an odd line total in interlaced mode: a design that counts whole lines would put both fields' vertical sync at the same pixel, with no half-line offset. Serration and equalization are checked pixel by pixel near the half-line boundary, where an off-by-one in the half-line position or in the width compare shows up as a moved edge. The run bit and live rewrites of the totals are also exercised: a counter that keeps running while stopped, or that tests for equality at the wrap, would run past a shrunken total and drift away from the reference.

// File: rtl/raster_sync_pkg.sv
package raster_sync_pkg;
  localparam int DW   = 12;
  localparam int AW   = 4;
  localparam int NREG = 1 << AW;
  localparam int PW   = DW + 1;

  localparam int RA_STATUS = 0;
  localparam int RA_HTOT   = 1;
  localparam int RA_HS_ON  = 2;
  localparam int RA_HS_OFF = 3;
  localparam int RA_HB_ON  = 4;
  localparam int RA_HB_OFF = 5;
  localparam int RA_VTOT   = 6;
  localparam int RA_VS_ON  = 7;
  localparam int RA_VS_OFF = 8;
  localparam int RA_VB_ON  = 9;
  localparam int RA_VB_OFF = 10;
  localparam int RA_EQ_W   = 11;
  localparam int RA_SERR_W = 12;
  localparam int RA_CUR_H  = 13;
  localparam int RA_CUR_V  = 14;
  localparam int RA_VINT   = 15;

  localparam int ST_COMP  = 0;
  localparam int ST_ILACE = 1;
  localparam int ST_SERR  = 2;
  localparam int ST_EQ    = 3;
  localparam int ST_RUN   = 10;

  function automatic logic [DW-1:0] reset_value(int idx, logic run);
    logic [DW-1:0] v;
    case (idx)
      RA_STATUS: begin v = DW'(12'h00F); v[ST_RUN] = run; end
      RA_HTOT:   v = DW'(910);
      RA_HS_ON:  v = DW'(0);
      RA_HS_OFF: v = DW'(67);
      RA_HB_ON:  v = DW'(890);
      RA_HB_OFF: v = DW'(150);
      RA_VTOT:   v = DW'(525);
      RA_VS_ON:  v = DW'(3);
      RA_VS_OFF: v = DW'(6);
      RA_VB_ON:  v = DW'(0);
      RA_VB_OFF: v = DW'(20);
      RA_EQ_W:   v = DW'(33);
      RA_SERR_W: v = DW'(67);
      RA_CUR_H:  v = DW'(455);
      RA_CUR_V:  v = DW'(100);
      default:   v = DW'(262);
    endcase
    return v;
  endfunction

  // window [s,e), wrapping when s > e
  function automatic logic in_win(logic [PW-1:0] x, logic [PW-1:0] s, logic [PW-1:0] e);
    return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
  endfunction
endpackage

// File: rtl/raster_sync_regs.sv
module raster_sync_regs
  import raster_sync_pkg::*;
#(
  parameter bit CLK_EN_DEFAULT = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DW-1:0]            wr_data_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_o[i] <= reset_value(i, CLK_EN_DEFAULT);
    end else if (clear_i) begin
      for (int i = 0; i < NREG; i++) regs_o[i] <= reset_value(i, CLK_EN_DEFAULT);
    end else if (wr_en_i) begin
      regs_o[wr_addr_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/raster_sync_cnt.sv
module raster_sync_cnt
  import raster_sync_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [DW-1:0] h_tot_i,
  input  logic [DW-1:0] v_tot_i,
  output logic [DW-1:0] h_o,
  output logic [DW-1:0] v_o
);
  logic h_last, v_last;

  // >= so a total written below the current count still wraps
  assign h_last = ({1'b0, h_o} + PW'(1)) >= {1'b0, h_tot_i};
  assign v_last = ({1'b0, v_o} + PW'(1)) >= {1'b0, v_tot_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= '0;
      v_o <= '0;
    end else if (clear_i) begin
      h_o <= '0;
      v_o <= '0;
    end else if (run_i) begin
      if (h_last) begin
        h_o <= '0;
        v_o <= v_last ? '0 : v_o + DW'(1);
      end else begin
        h_o <= h_o + DW'(1);
      end
    end
  end
endmodule

// File: rtl/raster_sync_decode.sv
module raster_sync_decode
  import raster_sync_pkg::*;
#(
  parameter int EQ_LINES = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic [DW-1:0]            h_i,
  input  logic [DW-1:0]            v_i,
  input  logic [NREG-1:0][DW-1:0]  regs_i,
  output logic [5:0]               pins_o
);
  localparam logic [PW-1:0] EQ2 = PW'(2 * EQ_LINES);

  logic          comp, ilace, serr_en, eq_en;
  logic [DW-1:0] h_tot, half_len, hh;
  logic          half;
  logic [PW-1:0] hp, vt, fh, hx;
  logic [PW-1:0] vs_on2, vs_off2, vb_on2, vb_off2;
  logic          hs_act, hb_act, vs_act, vb_act, eq_pre, eq_post;
  logic          cs_act, hg_act, vg_act, cur_act, vi_act;
  logic [5:0]    pins_d;
  logic          unused_status;

  assign comp    = regs_i[RA_STATUS][ST_COMP];
  assign ilace   = regs_i[RA_STATUS][ST_ILACE];
  assign serr_en = regs_i[RA_STATUS][ST_SERR];
  assign eq_en   = regs_i[RA_STATUS][ST_EQ];
  assign unused_status = ^regs_i[RA_STATUS][DW-1:4];

  assign h_tot    = regs_i[RA_HTOT];
  assign half_len = {1'b0, h_tot[DW-1:1]};
  assign half     = h_i >= half_len;
  assign hh       = half ? h_i - half_len : h_i;
  assign hp       = {v_i, half};
  assign vt       = {1'b0, regs_i[RA_VTOT]};
  assign fh       = (ilace && hp >= vt) ? hp - vt : hp;
  assign hx       = {1'b0, h_i};

  assign vs_on2  = {regs_i[RA_VS_ON], 1'b0};
  assign vs_off2 = {regs_i[RA_VS_OFF], 1'b0};
  assign vb_on2  = {regs_i[RA_VB_ON], 1'b0};
  assign vb_off2 = {regs_i[RA_VB_OFF], 1'b0};

  assign hs_act = in_win(hx, {1'b0, regs_i[RA_HS_ON]}, {1'b0, regs_i[RA_HS_OFF]});
  assign hb_act = in_win(hx, {1'b0, regs_i[RA_HB_ON]}, {1'b0, regs_i[RA_HB_OFF]});
  assign hg_act = in_win(hx, {1'b0, regs_i[RA_HS_OFF]}, {1'b0, regs_i[RA_HB_OFF]});
  assign vs_act = in_win(fh, vs_on2, vs_off2);
  assign vb_act = in_win(fh, vb_on2, vb_off2);
  assign vg_act = in_win(fh, vs_off2, vb_off2);

  assign eq_pre  = (fh + EQ2 >= vs_on2) && (fh < vs_on2);
  assign eq_post = (fh >= vs_off2) && (fh < vs_off2 + EQ2);

  always_comb begin
    if (vs_act)
      cs_act = serr_en ? (({1'b0, hh} + {1'b0, regs_i[RA_SERR_W]}) < {1'b0, half_len}) : 1'b1;
    else if (eq_en && (eq_pre || eq_post))
      cs_act = hh < regs_i[RA_EQ_W];
    else
      cs_act = hs_act;
  end

  assign cur_act = (h_i == regs_i[RA_CUR_H]) && (v_i == regs_i[RA_CUR_V]);
  assign vi_act  = v_i == regs_i[RA_VINT];

  assign pins_d = comp ? ~{cs_act, hb_act | vb_act, hg_act, vg_act, cur_act, vi_act}
                       : ~{hs_act, vs_act, hb_act, vb_act, 1'b0, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pins_o <= '1;
    else if (clear_i) pins_o <= '1;
    else              pins_o <= pins_d;
  end
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_sync_pkg::*;
#(
  parameter bit CLK_EN_DEFAULT = 1'b0,
  parameter int EQ_LINES       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          hsync_csync_o,
  output logic          vsync_cblank_o,
  output logic          hblank_hgate_o,
  output logic          vblank_vgate_o,
  output logic          cursor_o,
  output logic          vint_o
);
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           h_cnt, v_cnt;
  logic                    run;
  logic [5:0]              pins;

  assign run = regs[RA_STATUS][ST_RUN];

  raster_sync_regs #(.CLK_EN_DEFAULT(CLK_EN_DEFAULT)) u_regs (
    .clk_i, .rst_ni, .clear_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .regs_o(regs)
  );

  raster_sync_cnt u_cnt (
    .clk_i, .rst_ni, .clear_i,
    .run_i(run), .h_tot_i(regs[RA_HTOT]), .v_tot_i(regs[RA_VTOT]),
    .h_o(h_cnt), .v_o(v_cnt)
  );

  raster_sync_decode #(.EQ_LINES(EQ_LINES)) u_dec (
    .clk_i, .rst_ni, .clear_i,
    .h_i(h_cnt), .v_i(v_cnt), .regs_i(regs),
    .pins_o(pins)
  );

  assign {hsync_csync_o, vsync_cblank_o, hblank_hgate_o, vblank_vgate_o, cursor_o, vint_o} = pins;
endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk
  import raster_sync_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          run,
  input logic          st_comp,
  input logic [DW-1:0] h_tot,
  input logic [DW-1:0] h_cnt,
  input logic [DW-1:0] v_cnt,
  input logic          hsync_csync_o,
  input logic          vsync_cblank_o,
  input logic          hblank_hgate_o,
  input logic          vblank_vgate_o,
  input logic          cursor_o,
  input logic          vint_o
);
  assert_clear_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hsync_csync_o && vsync_cblank_o && hblank_hgate_o && vblank_vgate_o && cursor_o && vint_o));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !clear_i) |=> ($stable(h_cnt) && $stable(v_cnt)));

  assert_h_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !clear_i && (PW'(h_cnt) + PW'(1) >= PW'(h_tot))) |=> (h_cnt == '0));

  assert_v_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !clear_i && (PW'(h_cnt) + PW'(1) < PW'(h_tot))) |=> $stable(v_cnt));

  assert_extra_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_comp && !clear_i) |=> (cursor_o && vint_o));
endmodule

bind raster_sync_gen raster_sync_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .run(run),
  .st_comp(regs[0][0]), .h_tot(regs[1]), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .hsync_csync_o(hsync_csync_o), .vsync_cblank_o(vsync_cblank_o),
  .hblank_hgate_o(hblank_hgate_o), .vblank_vgate_o(vblank_vgate_o),
  .cursor_o(cursor_o), .vint_o(vint_o)
);

// File: tb/raster_sync_gen_bench.sv
module raster_sync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EQ_L = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic hs_o, vs_o, hb_o, vb_o, cur_o, vi_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  int mr[16];
  int mh, mv;
  logic [5:0] mexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_sync_gen u_raster_sync_gen (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .hsync_csync_o(hs_o), .vsync_cblank_o(vs_o), .hblank_hgate_o(hb_o),
    .vblank_vgate_o(vb_o), .cursor_o(cur_o), .vint_o(vi_o)
  );

  // defaults per R1, run bit 0
  task automatic load_defaults();
    int d[16] = '{15, 910, 0, 67, 890, 150, 525, 3, 6, 0, 20, 33, 67, 455, 100, 262};
    for (int i = 0; i < 16; i++) mr[i] = d[i];
    mh = 0; mv = 0;
  endtask

  function automatic bit win(int x, int s, int e);
    return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
  endfunction

  function automatic logic [5:0] model_out(int h, int v);
    int st = mr[0];
    bit comp = st[0], il = st[1], se = st[2], eq = st[3];
    int hl = mr[1] / 2;
    int half = (h >= hl) ? 1 : 0;
    int hh = half ? h - hl : h;
    int p = 2 * v + half;
    int f = (il && p >= mr[6]) ? p - mr[6] : p;
    bit hs = win(h, mr[2], mr[3]);
    bit hb = win(h, mr[4], mr[5]);
    bit vs = win(f, 2 * mr[7], 2 * mr[8]);
    bit vb = win(f, 2 * mr[9], 2 * mr[10]);
    bit in_eq = (f >= 2 * mr[7] - 2 * EQ_L && f < 2 * mr[7]) ||
                (f >= 2 * mr[8] && f < 2 * mr[8] + 2 * EQ_L);
    bit cs;
    if (vs) cs = se ? (hh + mr[12] < hl) : 1'b1;
    else if (eq && in_eq) cs = hh < mr[11];
    else cs = hs;
    if (comp)
      return ~{cs, hb | vb, win(h, mr[3], mr[5]), win(f, 2 * mr[8], 2 * mr[10]),
               (h == mr[13] && v == mr[14]), (v == mr[15])};
    return ~{hs, vs, hb, vb, 1'b0, 1'b0};
  endfunction

  task automatic model_edge();
    if (clear_i) begin
      mexp = '1;
      load_defaults();
    end else begin
      bit run = mr[0][10];
      mexp = model_out(mh, mv);
      if (run) begin
        if (mh + 1 >= mr[1]) begin
          mh = 0;
          mv = (mv + 1 >= mr[6]) ? 0 : mv + 1;
        end else mh = mh + 1;
      end
      if (wr_en_i) mr[wr_addr_i] = int'(wr_data_i);
    end
  endtask

  task automatic check(string req, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b (h=%0d v=%0d)", req, got, exp, mh, mv);
    end
  endtask

  function automatic logic [5:0] pins();
    return {hs_o, vs_o, hb_o, vb_o, cur_o, vi_o};
  endfunction

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_req, pins(), mexp);
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, int d);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 12'(d);
    cyc();
    wr_en_i = 1'b0;
  endtask

  initial begin
    logic [5:0] snap;
    load_defaults();
    mexp = '1;
    repeat (3) @(negedge clk);
    check("R1", pins(), 6'b111111);       // reset state
    rst_ni = 1'b1;

    cur_req = "R2";                       // default run bit 0: frozen
    run_n(40);

    cur_req = "R13";                      // default timing, composite interlaced
    wr(0, 12'h40F);
    run_n(2000);

    cur_req = "R1";
    clear_i = 1'b1;
    cyc();
    clear_i = 1'b0;
    check("R1", pins(), 6'b111111);
    cur_req = "R2";
    run_n(20);

    cur_req = "R12";                      // program compact timing while stopped
    wr(1, 40); wr(2, 2); wr(3, 6); wr(4, 36); wr(5, 8);
    wr(6, 12); wr(7, 3); wr(8, 5); wr(9, 10); wr(10, 2);
    wr(11, 2); wr(12, 4); wr(13, 10); wr(14, 4); wr(15, 7);

    cur_req = "R3 R4 R5";
    wr(0, 12'h400);
    run_n(1440);

    cur_req = "R7 R10 R11";
    wr(0, 12'h401);
    run_n(1000);

    cur_req = "R8 R9";
    wr(0, 12'h40D);
    run_n(1000);

    cur_req = "R6";
    wr(6, 11);
    wr(0, 12'h40F);
    run_n(1000);
    wr(0, 12'h402);
    run_n(500);

    cur_req = "R12";                      // live rewrites, shrinking total
    wr(0, 12'h40F);
    run_n(35);
    wr(1, 30);
    wr(3, 9);
    run_n(700);

    cur_req = "R2";
    wr(0, 12'h00F);
    snap = pins();
    run_n(60);
    check("R2", pins(), snap);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule